// File: doc/BRIEF.md
# Accumulator and Extension Shifter

This block holds a 48-bit accumulator register and a 48-bit extension register and shifts them on command. A command names a direction, a target and a 7-bit count. The target is the accumulator alone, the extension alone, or both registers joined into one 96-bit operand. In the joined operand the accumulator is the upper half and the extension is the lower half.

The two directions behave differently. A right shift is arithmetic: the operand's top bit is copied into every vacated position, and bits that pass the low end are discarded. A left shift is a rotation: bits that leave the top come back in at the bottom. Every shift completes in one clock through a logarithmic barrel network. A done pulse follows each accepted command.

Both registers can be loaded in parallel. A combinational output gives the accumulator masked by the extension, so the extension can act as a mask for logical work.

Top module: `accsh_unit`

## Requirements
- R1: After synchronous reset, both registers read zero and `done` is low.
- R2: When `load_en` is high at a clock edge, `a_out` and `q_out` take `load_a` and `load_q` after that edge. A command presented in the same cycle is dropped and produces no `done`.
- R3: `cmd_dir`=0 selects a right shift and `cmd_tgt`=0 selects the accumulator alone, `cmd_tgt`=1 the extension alone. A right shift of one register moves it down by `cmd_cnt`, fills the vacated upper bits with that register's bit 47 and discards the bits below bit 0. A count of 48 or more leaves every bit equal to the old bit 47.
- R4: `cmd_dir`=1 selects a left shift. A left shift of one register rotates it left by `cmd_cnt` modulo 48.
- R5: `cmd_tgt`=2 joins the registers as {A,Q}. A right shift of the pair is arithmetic on 96 bits with A bit 47 as sign, and bits cross from A into Q. A count of 96 or more fills both registers with the sign.
- R6: A left shift of the pair rotates the 96-bit value by `cmd_cnt` modulo 96, so bits leaving the top of A enter the bottom of Q and bits leaving the top of Q enter the bottom of A.
- R7: A command aimed at one register leaves the other register unchanged.
- R8: `cmd_tgt`=3 leaves both registers unchanged but still produces a `done` pulse.
- R9: `done` is high for exactly the one cycle after each accepted command, and low in every other cycle.
- R10: `mask_out` always equals the bitwise AND of the current A and Q.
- R11: A count of zero leaves the selected operand unchanged in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load of both registers |
| load_a | input | 48 | Accumulator load value |
| load_q | input | 48 | Extension load value |
| cmd_valid | input | 1 | Shift command present this cycle |
| cmd_dir | input | 1 | 0 right arithmetic, 1 left rotate |
| cmd_tgt | input | 2 | 0 A, 1 Q, 2 pair {A,Q}, 3 none |
| cmd_cnt | input | 7 | Shift count |
| a_out | output | 48 | Accumulator contents |
| q_out | output | 48 | Extension contents |
| mask_out | output | 48 | A AND Q |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default widths: 48-bit registers and a 7-bit count. With these widths the largest count, 127, is above both 48 and 96. This lets directed cases reach every path in the design: the sign fill of a single register, the sign fill of the joined pair, and the modulo wrap of rotations, including rotations by 50 and 100. The cases also cover bits moving across the A/Q boundary in both directions, and negative as well as positive operands.

// File: rtl/accsh_pkg.sv
package accsh_pkg;

    parameter int WORD_W = 48;
    parameter int CNT_W  = 7;
    localparam int PAIR_W = 2 * WORD_W;

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } shdir_e;

    typedef enum logic [1:0] {
        TGT_A    = 2'd0,
        TGT_Q    = 2'd1,
        TGT_PAIR = 2'd2,
        TGT_NONE = 2'd3
    } shtgt_e;

    typedef struct packed {
        shdir_e dir;
        shtgt_e tgt;
    } shop_t;

endpackage

// File: rtl/accsh_barrel.sv
module accsh_barrel
    import accsh_pkg::*;
#(
    parameter int W     = 48,
    parameter int CNT_W = 7
) (
    input  logic [W-1:0]     din,
    input  shdir_e           dir,
    input  logic [CNT_W-1:0] cnt,
    output logic [W-1:0]     dout
);

    logic [W-1:0] rs [CNT_W+1];
    logic [W-1:0] rl [CNT_W+1];
    logic         sgn;

    assign sgn   = din[W-1];
    assign rs[0] = din;
    assign rl[0] = din;

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int SH  = 1 << k;
        localparam int ROT = SH % W;
        logic [W-1:0] rs_sh;
        logic [W-1:0] rl_sh;

        if (SH >= W) begin : g_fill
            assign rs_sh = {W{sgn}};
        end else begin : g_part
            assign rs_sh = {{SH{sgn}}, rs[k][W-1:SH]};
        end

        if (ROT == 0) begin : g_norot
            assign rl_sh = rl[k];
        end else begin : g_rot
            assign rl_sh = {rl[k][W-1-ROT:0], rl[k][W-1:W-ROT]};
        end

        assign rs[k+1] = cnt[k] ? rs_sh : rs[k];
        assign rl[k+1] = cnt[k] ? rl_sh : rl[k];
    end

    assign dout = (dir == DIR_LEFT) ? rl[CNT_W] : rs[CNT_W];

endmodule

// File: rtl/accsh_mask.sv
module accsh_mask #(
    parameter int W = 48
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] msk,
    output logic [W-1:0] res
);

    assign res = acc & msk;

endmodule

// File: rtl/accsh_unit.sv
module accsh_unit
    import accsh_pkg::*;
#(
    parameter int WORD_W = accsh_pkg::WORD_W,
    parameter int CNT_W  = accsh_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_a,
    input  logic [WORD_W-1:0] load_q,
    input  logic              cmd_valid,
    input  logic              cmd_dir,
    input  logic [1:0]        cmd_tgt,
    input  logic [CNT_W-1:0]  cmd_cnt,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] q_out,
    output logic [WORD_W-1:0] mask_out,
    output logic              done
);

    localparam int PW = 2 * WORD_W;

    logic [WORD_W-1:0] a_r, q_r, a_nx, q_nx;
    logic [WORD_W-1:0] a_sh, q_sh;
    logic [PW-1:0]     pair_sh;
    logic              done_r;
    shop_t             op;

    assign op.dir = shdir_e'(cmd_dir);
    assign op.tgt = shtgt_e'(cmd_tgt);

    accsh_barrel #(.W(WORD_W), .CNT_W(CNT_W)) u_sh_a (
        .din(a_r), .dir(op.dir), .cnt(cmd_cnt), .dout(a_sh)
    );

    accsh_barrel #(.W(WORD_W), .CNT_W(CNT_W)) u_sh_q (
        .din(q_r), .dir(op.dir), .cnt(cmd_cnt), .dout(q_sh)
    );

    accsh_barrel #(.W(PW), .CNT_W(CNT_W)) u_sh_pair (
        .din({a_r, q_r}), .dir(op.dir), .cnt(cmd_cnt), .dout(pair_sh)
    );

    accsh_mask #(.W(WORD_W)) u_mask (
        .acc(a_r), .msk(q_r), .res(mask_out)
    );

    always_comb begin
        a_nx = a_r;
        q_nx = q_r;
        unique case (op.tgt)
            TGT_A:    a_nx = a_sh;
            TGT_Q:    q_nx = q_sh;
            TGT_PAIR: {a_nx, q_nx} = pair_sh;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_r    <= '0;
            q_r    <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= cmd_valid & ~load_en;
            if (load_en) begin
                a_r <= load_a;
                q_r <= load_q;
            end else if (cmd_valid) begin
                a_r <= a_nx;
                q_r <= q_nx;
            end
        end
    end

    assign a_out = a_r;
    assign q_out = q_r;
    assign done  = done_r;

endmodule

// File: rtl/accsh_chk.sv
module accsh_chk #(
    parameter int WORD_W = 48,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              load_en,
    input logic [WORD_W-1:0] load_a,
    input logic [WORD_W-1:0] load_q,
    input logic              cmd_valid,
    input logic              cmd_dir,
    input logic [1:0]        cmd_tgt,
    input logic [CNT_W-1:0]  cmd_cnt,
    input logic [WORD_W-1:0] a_out,
    input logic [WORD_W-1:0] q_out,
    input logic              done
);

    AST_LOAD_A: assert property (@(posedge clk) disable iff (rst)
        load_en |=> a_out == $past(load_a));  // R2
    AST_LOAD_Q: assert property (@(posedge clk) disable iff (rst)
        load_en |=> q_out == $past(load_q));  // R2
    AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !load_en) |=> done);  // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && !load_en) |=> !done);  // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && !load_en) |=> ($stable(a_out) && $stable(q_out)));  // R7
    AST_SEL_A_KEEPS_Q: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !load_en && cmd_tgt == 2'd0) |=> $stable(q_out));  // R7
    AST_SEL_Q_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !load_en && cmd_tgt == 2'd1) |=> $stable(a_out));  // R7
    AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !load_en && cmd_tgt == 2'd3) |=> ($stable(a_out) && $stable(q_out)));  // R8
    AST_RIGHT_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !load_en && !cmd_dir && cmd_tgt != 2'd1)
        |=> $stable(a_out[WORD_W-1]));  // R5

endmodule

bind accsh_unit accsh_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_a(load_a), .load_q(load_q),
    .cmd_valid(cmd_valid), .cmd_dir(cmd_dir), .cmd_tgt(cmd_tgt), .cmd_cnt(cmd_cnt),
    .a_out(a_out), .q_out(q_out), .done(done)
);

// File: tb/accsh_unit_tb_top.sv
module accsh_unit_tb_top;

    localparam int W = 48;
    localparam int C = 7;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_en;
    logic [W-1:0] load_a, load_q;
    logic         cmd_valid;
    logic         cmd_dir;
    logic [1:0]   cmd_tgt;
    logic [C-1:0] cmd_cnt;
    logic [W-1:0] a_out, q_out, mask_out;
    logic         done;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] ma, mq;

    always #5 clk = ~clk;

    accsh_unit dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_a(load_a), .load_q(load_q),
        .cmd_valid(cmd_valid), .cmd_dir(cmd_dir), .cmd_tgt(cmd_tgt), .cmd_cnt(cmd_cnt),
        .a_out(a_out), .q_out(q_out), .mask_out(mask_out), .done(done)
    );

    function automatic logic [2*W-1:0] m_right(input logic [2*W-1:0] x, input int w, input int n);
        logic [2*W-1:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = (i + n < w) ? x[i+n] : x[w-1];
        return r;
    endfunction

    function automatic logic [2*W-1:0] m_left(input logic [2*W-1:0] x, input int w, input int n);
        logic [2*W-1:0] r = '0;
        for (int i = 0; i < w; i++) r[(i + n) % w] = x[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] q);
        load_en = 1'b1; load_a = a; load_q = q;
        @(negedge clk);
        load_en = 1'b0;
        ma = a; mq = q;
    endtask

    task automatic do_shift(input string req, input logic d, input logic [1:0] t, input int n);
        logic [2*W-1:0] p;
        cmd_valid = 1'b1; cmd_dir = d; cmd_tgt = t; cmd_cnt = C'(n);
        case (t)
            2'd0: ma = d ? m_left({48'b0, ma}, W, n)[W-1:0] : m_right({48'b0, ma}, W, n)[W-1:0];
            2'd1: mq = d ? m_left({48'b0, mq}, W, n)[W-1:0] : m_right({48'b0, mq}, W, n)[W-1:0];
            2'd2: begin
                p = d ? m_left({ma, mq}, 2*W, n) : m_right({ma, mq}, 2*W, n);
                ma = p[2*W-1:W]; mq = p[W-1:0];
            end
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " A"}, a_out, ma);
        check({req, " Q"}, q_out, mq);
        check({req, " done"}, W'(done), W'(1));
        @(negedge clk);
        check({req, " done drop"}, W'(done), W'(0));
    endtask

    task automatic t_reset;
        check("R1 A", a_out, '0);
        check("R1 Q", q_out, '0);
        check("R1 done", W'(done), '0);
    endtask

    task automatic t_load_priority;
        do_load(48'h8000_1234_5678, 48'h0F0F_0F0F_0F0F);
        check("R2 A", a_out, 48'h8000_1234_5678);
        check("R2 Q", q_out, 48'h0F0F_0F0F_0F0F);
        load_en = 1'b1; load_a = 48'h1; load_q = 48'h2;
        cmd_valid = 1'b1; cmd_dir = 1'b1; cmd_tgt = 2'd2; cmd_cnt = 7'd5;
        @(negedge clk);
        load_en = 1'b0; cmd_valid = 1'b0; ma = 48'h1; mq = 48'h2;
        check("R2 load wins A", a_out, 48'h1);
        check("R2 load wins Q", q_out, 48'h2);
        check("R2 no done", W'(done), '0);
    endtask

    task automatic t_single;
        do_load(48'h8000_0000_00F1, 48'h7123_4567_89AB);
        do_shift("R3 A right neg", 1'b0, 2'd0, 4);
        do_shift("R3 Q right pos", 1'b0, 2'd1, 13);
        do_load(48'h9000_0000_0001, 48'h0000_0000_0003);
        do_shift("R3 A right fill", 1'b0, 2'd0, 60);
        check("R3 fill all ones", a_out, '1);
        do_shift("R4 Q left wrap", 1'b1, 2'd1, 50);
        check("R4 Q rot 2", q_out, 48'h0000_0000_000C);
        do_load(48'hC000_0000_0001, 48'h5555_AAAA_1234);
        do_shift("R4 A left", 1'b1, 2'd0, 3);
        check("R4 A rot 3", a_out, 48'h0000_0000_000E);
        check("R7 Q untouched", q_out, 48'h5555_AAAA_1234);
    endtask

    task automatic t_pair;
        do_load(48'h8000_0000_0003, 48'h0000_0000_0010);
        do_shift("R5 pair right", 1'b0, 2'd2, 4);
        check("R5 bits cross", q_out, 48'h3000_0000_0001);
        do_load(48'h4000_0000_0000, 48'hFFFF_FFFF_FFFF);
        do_shift("R5 pair right fill pos", 1'b0, 2'd2, 100);
        check("R5 fill Q zero", q_out, '0);
        do_load(48'h8000_0000_0000, 48'h0);
        do_shift("R5 pair right fill neg", 1'b0, 2'd2, 127);
        do_load(48'hC000_0000_0000, 48'h8000_0000_0001);
        do_shift("R6 pair left", 1'b1, 2'd2, 1);
        check("R6 A gets Q top", a_out, 48'h8000_0000_0001);
        check("R6 Q gets A top", q_out, 48'h0000_0000_0003);
        do_shift("R6 pair left wrap", 1'b1, 2'd2, 100);
    endtask

    task automatic t_misc;
        do_load(48'hF0F0_1234_FFFF, 48'h0FF0_FF00_00F0);
        check("R10 mask", mask_out, 48'h00F0_1200_00F0);
        do_shift("R11 zero right", 1'b0, 2'd2, 0);
        do_shift("R11 zero left", 1'b1, 2'd0, 0);
        check("R11 A same", a_out, 48'hF0F0_1234_FFFF);
        do_shift("R8 none", 1'b1, 2'd3, 9);
        check("R8 A same", a_out, 48'hF0F0_1234_FFFF);
        check("R8 Q same", q_out, 48'h0FF0_FF00_00F0);
        repeat (3) @(negedge clk);
        check("R9 idle done", W'(done), '0);
        check("R10 mask after", mask_out, a_out & q_out);
    endtask

    initial begin
        rst = 1'b1; load_en = 1'b0; load_a = '0; load_q = '0;
        cmd_valid = 1'b0; cmd_dir = 1'b0; cmd_tgt = '0; cmd_cnt = '0;
        ma = '0; mq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_priority();
        t_single();
        t_pair();
        t_misc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule